// File: doc/BRIEF.md
# Latency-Configurable Memory with Split Read/Write Access

This block wraps a storage array that reads combinationally and writes on the clock edge, and gives it three access points: a dedicated read port, a dedicated write port, and a combined port that either reads or writes in a given cycle, selected by a mode bit. Valid-qualified delay stages stretch the bare array to the read latency and the write latency chosen by parameter. A policy parameter decides what a read returns when a write to the same word lands in the same cycle: the previous contents or the newly written ones.

The policy also decides where the read delay sits. Under the old-data policy the address reaches the array at once and the returned word passes through a chain of data registers. Under the new-data policy the address passes through the delay chain and the array output drives the port directly. The write command (address, byte mask, data) is delayed by one stage fewer than the write latency, because the array write adds the last cycle. Every pipeline stage registers its valid bit on every cycle, and its payload loads only while the incoming valid is high.

The ports have no ready signal and cannot apply back-pressure. Every command offered with its enable high is taken in that cycle. A returned word is shown for one cycle with its valid flag high, and the consumer must take it in that cycle.

Top module: `latmem_top`

## Requirements
- R1: While reset is asserted and after its release, `rd_valid` and `rw_rvalid` are 0 until a read is issued. Under the old-data policy with a read latency above zero, `rd_data` and `rw_rdata` read zero.
- R2: A read issued on the read port with `rd_en` high in cycle t returns the addressed word on `rd_data`, with `rd_valid` high, in cycle t+READ_LATENCY (in cycle t itself when the latency is 0).
- R3: A write issued in cycle t reaches the array at the clock edge that ends cycle t+WRITE_LATENCY-1. Under the old-data policy, a read that reaches the array in that same cycle does not see it.
- R4: Mask bit i enables data bits [8i+7:8i]. Byte lanes whose mask bit is 0 keep their contents.
- R5: On the combined port, `rw_en` with `rw_wmode`=1 writes `rw_wdata` under `rw_wmask` and produces no `rw_rvalid`. `rw_en` with `rw_wmode`=0 reads without changing the memory and returns the word on `rw_rdata`, with `rw_rvalid` high, READ_LATENCY cycles later.
- R6: Under the old-data policy (RUW_OLD=1), a read samples the array in its issue cycle, and a write that lands at the edge ending that cycle is not visible in the returned word.
- R7: Under the new-data policy (RUW_OLD=0) with a nonzero read latency, the array is read at the delayed address. A write and a read to the same word issued in the same cycle with WRITE_LATENCY <= READ_LATENCY return the written data.
- R8: Under the new-data policy with READ_LATENCY=0, a write reaching the array in the same cycle as a read of the same word is forwarded to the read data combinationally, lane by lane under its mask.
- R9: When both write paths land on the same word in the same cycle, the combined port's enabled lanes win, and the other enabled lanes take the write port's data.
- R10: Under the old-data policy with a nonzero read latency, `rd_data` holds its last value in every cycle in which `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read port enable |
| rd_addr | input | $clog2(DEPTH) | Read port word address |
| rd_data | output | DATA_W | Read port returned word |
| rd_valid | output | 1 | Read port returned word is valid |
| wr_en | input | 1 | Write port enable |
| wr_addr | input | $clog2(DEPTH) | Write port word address |
| wr_mask | input | DATA_W/8 | Write port byte-lane enables |
| wr_data | input | DATA_W | Write port data |
| rw_en | input | 1 | Combined port enable |
| rw_wmode | input | 1 | Combined port mode: 1 write, 0 read |
| rw_addr | input | $clog2(DEPTH) | Combined port word address |
| rw_wmask | input | DATA_W/8 | Combined port byte-lane enables |
| rw_wdata | input | DATA_W | Combined port write data |
| rw_rdata | output | DATA_W | Combined port returned word |
| rw_rvalid | output | 1 | Combined port returned word is valid |

## Verification
The bench drives three instances with the same stimulus, each with 32-bit words and 16 entries. The first uses a read latency of 2, a write latency of 2 and the old-data policy. Its write pipeline then has one stage, so a read issued one cycle after a write meets it exactly at the array and must return the previous word. The second uses a latency of 1 on both paths with the new-data policy, which shows a same-cycle write through the delayed address. The third uses a read latency of 0 with the new-data policy, which puts the combinational write forwarding path under test. Between them these cover every structural variant of the read path.

// File: rtl/memlat_pkg.sv
package memlat_pkg;
  localparam int LANE_W  = 8;
  localparam int MAX_LAT = 4;
  localparam int N_CHAN  = 2;  // channel 0: dedicated port, channel 1: combined port
endpackage

// File: rtl/memlat_pipe.sv
module memlat_pipe #(
  parameter int STAGES = 1,
  parameter int W      = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_pay,
  output logic         out_vld,
  output logic [W-1:0] out_pay
);
  logic [STAGES-1:0]        vld_q;
  logic [STAGES-1:0][W-1:0] pay_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      pay_q <= '0;
    end else begin
      vld_q[0] <= in_vld;
      if (in_vld) pay_q[0] <= in_pay;
      for (int s = 1; s < STAGES; s++) begin
        vld_q[s] <= vld_q[s-1];
        if (vld_q[s-1]) pay_q[s] <= pay_q[s-1];
      end
    end
  end

  assign out_vld = vld_q[STAGES-1];
  assign out_pay = pay_q[STAGES-1];
endmodule

// File: rtl/memlat_store.sv
module memlat_store
  import memlat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int AW     = 4,
  parameter bit BYPASS = 1'b0
) (
  input  logic                        clk,
  input  logic [N_CHAN-1:0]           we,
  input  logic [N_CHAN-1:0][AW-1:0]   wa,
  input  logic [N_CHAN-1:0][DATA_W/LANE_W-1:0] wm,
  input  logic [N_CHAN-1:0][DATA_W-1:0] wd,
  input  logic [N_CHAN-1:0][AW-1:0]   ra,
  output logic [N_CHAN-1:0][DATA_W-1:0] rd
);
  localparam int LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // Later channel is applied last, so the combined port wins on overlap.
  always_ff @(posedge clk) begin
    for (int c = 0; c < N_CHAN; c++) begin
      for (int l = 0; l < LANES; l++) begin
        if (we[c] && wm[c][l])
          cells[wa[c]][l*LANE_W +: LANE_W] <= wd[c][l*LANE_W +: LANE_W];
      end
    end
  end

  for (genvar p = 0; p < N_CHAN; p++) begin : g_rport
    if (BYPASS) begin : g_fwd
      always_comb begin
        rd[p] = cells[ra[p]];
        for (int c = 0; c < N_CHAN; c++) begin
          for (int l = 0; l < LANES; l++) begin
            if (we[c] && wm[c][l] && (wa[c] == ra[p]))
              rd[p][l*LANE_W +: LANE_W] = wd[c][l*LANE_W +: LANE_W];
          end
        end
      end
    end else begin : g_plain
      assign rd[p] = cells[ra[p]];
    end
  end
endmodule

// File: rtl/memlat_rdchan.sv
module memlat_rdchan #(
  parameter int DATA_W  = 32,
  parameter int AW      = 4,
  parameter int RL      = 2,
  parameter bit RUW_OLD = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [AW-1:0]     addr,
  output logic [AW-1:0]     arr_addr,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_vld
);
  if (RL == 0) begin : g_comb
    assign arr_addr = addr;
    assign out_data = arr_data;
    assign out_vld  = en;
  end else if (RUW_OLD) begin : g_datapipe
    // Address goes straight in; the returned word is delayed.
    assign arr_addr = addr;
    memlat_pipe #(.STAGES(RL), .W(DATA_W)) u_dpipe (
      .clk(clk), .rst_n(rst_n),
      .in_vld(en), .in_pay(arr_data),
      .out_vld(out_vld), .out_pay(out_data)
    );
  end else begin : g_cmdpipe
    // Address is delayed; the array output drives the port directly.
    memlat_pipe #(.STAGES(RL), .W(AW)) u_apipe (
      .clk(clk), .rst_n(rst_n),
      .in_vld(en), .in_pay(addr),
      .out_vld(out_vld), .out_pay(arr_addr)
    );
    assign out_data = arr_data;
  end
endmodule

// File: rtl/latmem_top.sv
module latmem_top
  import memlat_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int DEPTH         = 16,
  parameter int READ_LATENCY  = 2,
  parameter int WRITE_LATENCY = 1,
  parameter bit RUW_OLD       = 1'b1,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [LANES-1:0]  wr_mask,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rw_en,
  input  logic              rw_wmode,
  input  logic [AW-1:0]     rw_addr,
  input  logic [LANES-1:0]  rw_wmask,
  input  logic [DATA_W-1:0] rw_wdata,
  output logic [DATA_W-1:0] rw_rdata,
  output logic              rw_rvalid
);
  localparam int WSTAGES = WRITE_LATENCY - 1;
  localparam int WCMD_W  = AW + LANES + DATA_W;
  localparam bit BYPASS  = (READ_LATENCY == 0) && !RUW_OLD;

  // Split the combined port into its read half and its write half.
  logic rw_rd_en, rw_wr_en;
  assign rw_rd_en = rw_en & ~rw_wmode;
  assign rw_wr_en = rw_en &  rw_wmode;

  logic [N_CHAN-1:0]              c_wen;
  logic [N_CHAN-1:0][WCMD_W-1:0]  c_wcmd;
  logic [N_CHAN-1:0]              c_ren;
  logic [N_CHAN-1:0][AW-1:0]      c_raddr;

  assign c_wen   = {rw_wr_en, wr_en};
  assign c_wcmd  = {{rw_addr, rw_wmask, rw_wdata}, {wr_addr, wr_mask, wr_data}};
  assign c_ren   = {rw_rd_en, rd_en};
  assign c_raddr = {rw_addr, rd_addr};

  logic [N_CHAN-1:0]              a_we;
  logic [N_CHAN-1:0][AW-1:0]      a_wa;
  logic [N_CHAN-1:0][LANES-1:0]   a_wm;
  logic [N_CHAN-1:0][DATA_W-1:0]  a_wd;
  logic [N_CHAN-1:0][AW-1:0]      a_ra;
  logic [N_CHAN-1:0][DATA_W-1:0]  a_rd;
  logic [N_CHAN-1:0][DATA_W-1:0]  o_data;
  logic [N_CHAN-1:0]              o_vld;

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    logic              wv;
    logic [WCMD_W-1:0] wp;

    if (WSTAGES == 0) begin : g_wdirect
      assign wv = c_wen[c];
      assign wp = c_wcmd[c];
    end else begin : g_wpipe
      memlat_pipe #(.STAGES(WSTAGES), .W(WCMD_W)) u_wpipe (
        .clk(clk), .rst_n(rst_n),
        .in_vld(c_wen[c]), .in_pay(c_wcmd[c]),
        .out_vld(wv), .out_pay(wp)
      );
    end

    assign a_we[c] = wv;
    assign a_wa[c] = wp[WCMD_W-1 -: AW];
    assign a_wm[c] = wp[DATA_W +: LANES];
    assign a_wd[c] = wp[DATA_W-1:0];

    memlat_rdchan #(
      .DATA_W(DATA_W), .AW(AW), .RL(READ_LATENCY), .RUW_OLD(RUW_OLD)
    ) u_rdchan (
      .clk(clk), .rst_n(rst_n),
      .en(c_ren[c]), .addr(c_raddr[c]),
      .arr_addr(a_ra[c]), .arr_data(a_rd[c]),
      .out_data(o_data[c]), .out_vld(o_vld[c])
    );
  end

  memlat_store #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW), .BYPASS(BYPASS)
  ) u_store (
    .clk(clk),
    .we(a_we), .wa(a_wa), .wm(a_wm), .wd(a_wd),
    .ra(a_ra), .rd(a_rd)
  );

  assign rd_data   = o_data[0];
  assign rd_valid  = o_vld[0];
  assign rw_rdata  = o_data[1];
  assign rw_rvalid = o_vld[1];
endmodule

// File: rtl/memlat_chk.sv
module memlat_chk #(
  parameter int DATA_W        = 32,
  parameter int AW            = 4,
  parameter int READ_LATENCY  = 2,
  parameter bit RUW_OLD       = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              rw_en,
  input logic              rw_wmode,
  input logic [DATA_W-1:0] rw_rdata,
  input logic              rw_rvalid
);
  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!rd_valid && !rw_rvalid));

  if (READ_LATENCY == 0) begin : g_lat0
    assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid == rd_en);
    assert_rw_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rw_rvalid == (rw_en && !rw_wmode));
  end else begin : g_latn
    assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (age > READ_LATENCY) |-> (rd_valid == $past(rd_en, READ_LATENCY)));
    assert_rw_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (age > READ_LATENCY) |-> (rw_rvalid == $past(rw_en && !rw_wmode, READ_LATENCY)));
  end

  if (RUW_OLD && READ_LATENCY > 0) begin : g_hold
    assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (age > 1 && !rd_valid) |-> $stable(rd_data));
  end
endmodule

bind latmem_top memlat_chk #(
  .DATA_W(DATA_W), .AW(AW), .READ_LATENCY(READ_LATENCY), .RUW_OLD(RUW_OLD)
) u_memlat_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
  .rw_en(rw_en), .rw_wmode(rw_wmode), .rw_rdata(rw_rdata), .rw_rvalid(rw_rvalid)
);

// File: tb/test_latmem_top.sv
module test_latmem_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        rd_en = 0, wr_en = 0, rw_en = 0, rw_wmode = 0;
  logic [3:0]  rd_addr = 0, wr_addr = 0, rw_addr = 0;
  logic [3:0]  wr_mask = 0, rw_wmask = 0;
  logic [31:0] wr_data = 0, rw_wdata = 0;

  logic [31:0] rdA, rdB, rdC, rwA, rwB, rwC;
  logic        vA, vB, vC, rvA, rvB, rvC;

  int n_chk = 0;
  int n_fail = 0;

  // A: old-data, RL=2, WL=2
  latmem_top #(.DATA_W(32), .DEPTH(16), .READ_LATENCY(2), .WRITE_LATENCY(2), .RUW_OLD(1'b1)) i_latmem_top (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rdA), .rd_valid(vA),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask), .wr_data(wr_data),
    .rw_en(rw_en), .rw_wmode(rw_wmode), .rw_addr(rw_addr), .rw_wmask(rw_wmask), .rw_wdata(rw_wdata),
    .rw_rdata(rwA), .rw_rvalid(rvA));
  // B: new-data, RL=1, WL=1
  latmem_top #(.DATA_W(32), .DEPTH(16), .READ_LATENCY(1), .WRITE_LATENCY(1), .RUW_OLD(1'b0)) i_latmem_top_b (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rdB), .rd_valid(vB),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask), .wr_data(wr_data),
    .rw_en(rw_en), .rw_wmode(rw_wmode), .rw_addr(rw_addr), .rw_wmask(rw_wmask), .rw_wdata(rw_wdata),
    .rw_rdata(rwB), .rw_rvalid(rvB));
  // C: new-data, RL=0, WL=1
  latmem_top #(.DATA_W(32), .DEPTH(16), .READ_LATENCY(0), .WRITE_LATENCY(1), .RUW_OLD(1'b0)) i_latmem_top_c (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rdC), .rd_valid(vC),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask), .wr_data(wr_data),
    .rw_en(rw_en), .rw_wmode(rw_wmode), .rw_addr(rw_addr), .rw_wmask(rw_wmask), .rw_wdata(rw_wdata),
    .rw_rdata(rwC), .rw_rvalid(rvC));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // Caller may set write inputs in the same slot; they are dropped after one cycle.
  task automatic read_check(input logic [3:0] a, input logic [31:0] ea, eb, ec, input string tag);
    rd_en = 1; rd_addr = a; #1;
    check({tag, " C rd_data"}, rdC, ec);
    check({tag, " C rd_valid"}, {31'd0, vC}, 32'd1);
    step(); rd_en = 0; wr_en = 0; rw_en = 0; #1;
    check({tag, " B rd_data"}, rdB, eb);
    check({tag, " B rd_valid"}, {31'd0, vB}, 32'd1);
    step();
    check({tag, " A rd_data"}, rdA, ea);
    check({tag, " A rd_valid"}, {31'd0, vA}, 32'd1);
    step();
    check({tag, " valids low"}, {29'd0, vA, vB, vC}, 32'd0);
  endtask

  task automatic rw_read_check(input logic [3:0] a, input logic [31:0] e, input string tag);
    rw_en = 1; rw_wmode = 0; rw_addr = a; rw_wmask = 4'hF; rw_wdata = 32'h0; #1;
    check({tag, " C rw_rdata"}, rwC, e);
    check({tag, " C rw_rvalid"}, {31'd0, rvC}, 32'd1);
    step(); rw_en = 0; #1;
    check({tag, " B rw_rdata"}, rwB, e);
    check({tag, " B rw_rvalid"}, {31'd0, rvB}, 32'd1);
    step();
    check({tag, " A rw_rdata"}, rwA, e);
    check({tag, " A rw_rvalid"}, {31'd0, rvA}, 32'd1);
    step();
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] m, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_mask = m; wr_data = d;
    step(); wr_en = 0;
  endtask

  task automatic t_reset();
    check("R1 reset valids", {26'd0, vA, vB, vC, rvA, rvB, rvC}, 32'd0);
    check("R1 reset A rd_data", rdA, 32'd0);
    check("R1 reset A rw_rdata", rwA, 32'd0);
  endtask

  task automatic t_basic();
    wr(4'd1, 4'hF, 32'h1122_3344);
    wr(4'd2, 4'hF, 32'hA5A5_5A5A);
    idle(3);
    read_check(4'd1, 32'h1122_3344, 32'h1122_3344, 32'h1122_3344, "R2 read w1");
    read_check(4'd2, 32'hA5A5_5A5A, 32'hA5A5_5A5A, 32'hA5A5_5A5A, "R2 read w2");
  endtask

  task automatic t_mask();
    wr(4'd1, 4'b0101, 32'hFFFF_FFFF);
    idle(3);
    read_check(4'd1, 32'h11FF_33FF, 32'h11FF_33FF, 32'h11FF_33FF, "R4 lane mask");
  endtask

  task automatic t_rw_port();
    rw_en = 1; rw_wmode = 1; rw_addr = 4'd5; rw_wmask = 4'hF; rw_wdata = 32'hCAFE_F00D;
    step(); rw_en = 0;
    for (int i = 0; i < 3; i++) begin
      check("R5 no rvalid on write", {29'd0, rvA, rvB, rvC}, 32'd0);
      step();
    end
    rw_read_check(4'd5, 32'hCAFE_F00D, "R5 rw read");
    idle(2);
    read_check(4'd5, 32'hCAFE_F00D, 32'hCAFE_F00D, 32'hCAFE_F00D, "R5 read leaves word");
  endtask

  task automatic t_hold();
    read_check(4'd2, 32'hA5A5_5A5A, 32'hA5A5_5A5A, 32'hA5A5_5A5A, "R10 prime");
    rd_addr = 4'd1;
    idle(3);
    check("R10 A holds", rdA, 32'hA5A5_5A5A);
    check("R10 A valid low", {31'd0, vA}, 32'd0);
  endtask

  task automatic t_same_cycle();
    wr(4'd7, 4'hF, 32'h0000_0007);
    idle(3);
    wr_en = 1; wr_addr = 4'd7; wr_mask = 4'hF; wr_data = 32'h7777_7777;
    read_check(4'd7, 32'h0000_0007, 32'h7777_7777, 32'h7777_7777, "R6 R7 R8 same-cycle");
    idle(2);
  endtask

  task automatic t_landing();
    wr(4'd8, 4'hF, 32'h0000_0008);
    idle(3);
    wr(4'd8, 4'hF, 32'h8888_8888);
    read_check(4'd8, 32'h0000_0008, 32'h8888_8888, 32'h8888_8888, "R3 R6 landing");
    idle(2);
    read_check(4'd8, 32'h8888_8888, 32'h8888_8888, 32'h8888_8888, "R3 after landing");
  endtask

  task automatic t_priority();
    wr_en = 1; wr_addr = 4'd9; wr_mask = 4'hF; wr_data = 32'hAAAA_AAAA;
    rw_en = 1; rw_wmode = 1; rw_addr = 4'd9; rw_wmask = 4'b0011; rw_wdata = 32'hBBBB_BBBB;
    step(); wr_en = 0; rw_en = 0;
    idle(3);
    read_check(4'd9, 32'hAAAA_BBBB, 32'hAAAA_BBBB, 32'hAAAA_BBBB, "R9 overlap");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_basic();
    t_mask();
    t_rw_port();
    t_hold();
    t_same_cycle();
    t_landing();
    t_priority();
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule